// File: doc/BRIEF.md
# Multi-Modulus Prescaler (32/33/47/48)

This block divides a fast input clock by 32, 33, 47 or 48. The fast clock is modelled as a one-cycle enable, `in_tick`, on a single system clock. Each enabled cycle counts as one input period. The core is a small divider that closes a core period after either two or three input ticks. It feeds a chain of four toggle stages, which give a fixed post-division of sixteen. A two-input NAND of the chain's all-ones state and the modulus input `swallow_req` gives a mode-control bit. A band input `band_hi` sets the polarity with which that bit drives the core.

In the low band the core normally closes after two ticks. When the modulus input is high, it stretches exactly one core period per output period to three ticks. In the high band the polarity is inverted. The core normally closes after three ticks, and the modulus input shortens one core period to two ticks. The two higher ratios therefore need no additional flip-flops.

The divided output is the last toggle stage. Its period, counted in input ticks, equals the selected ratio. There is no data stream in or out of this block, so all pins are plain control and clock-like signals with no valid/ready handshake.

Top module: `mmod_prescaler`

## Requirements
- R1: An active-low asynchronous reset clears every stage, and `div_out` is low during reset and on the first cycle after its release.
- R2: With `band_hi`=0 and `swallow_req`=0, `div_out` has a period of 32 input ticks, high for 16 ticks and low for 16.
- R3: With `band_hi`=0 and `swallow_req`=1, `div_out` has a period of 33 input ticks, high for 17 ticks and low for 16.
- R4: With `band_hi`=1 and `swallow_req`=0, `div_out` has a period of 48 input ticks, high for 24 ticks and low for 24.
- R5: With `band_hi`=1 and `swallow_req`=1, `div_out` has a period of 47 input ticks, high for 23 ticks and low for 24.
- R6: A clock cycle with `in_tick`=0 changes no state and no output. All periods are counted in ticks, however the ticks are spaced.
- R7: Raising `swallow_req` changes the ratio by exactly one tick from the band's base. The base is 32 for `band_hi`=0 and 48 for `band_hi`=1. The change is upward in the low band and downward in the high band.
- R8: A core period lasts two or three ticks, and the swallow period falls in the high half of the output. The low phase therefore always consists of eight base-mode core periods: 16 ticks in the low band and 24 in the high band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_tick | input | 1 | One fast-clock period per high cycle |
| band_hi | input | 1 | 0: 32/33 band, 1: 47/48 band |
| swallow_req | input | 1 | 1: swallow (or add) one tick per output period |
| div_out | output | 1 | Divided clock (last toggle stage) |

## Verification
The hardest case to bring about is the single altered core period. It occurs only while the four stages are all ones. A fault there shifts one output period by a tick while leaving the low phase and the other periods intact. The bench steps through all four band/modulus settings under both a dense tick stream and a pseudo-random gapped stream, and measures several complete periods after each change. The high time, low time and period are each compared separately, so a swallow applied in the wrong place, in the wrong direction or more than once shows up.

// File: rtl/mmod_pkg.sv
package mmod_pkg;

  typedef enum logic {
    CORE_SHORT = 1'b0,
    CORE_LONG  = 1'b1
  } core_mode_e;

endpackage

// File: rtl/mmod_core23.sv
module mmod_core23 #(
  parameter int N1 = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  mmod_pkg::core_mode_e   mode,
  output logic                   period_end
);
  localparam int CW = $clog2(N1 + 1) + 1;

  logic [CW-1:0] cnt;
  logic          at_last;

  always_comb begin
    if (mode == mmod_pkg::CORE_LONG) at_last = (cnt >= CW'(N1));
    else                             at_last = (cnt >= CW'(N1 - 1));
  end

  assign period_end = tick & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (period_end) cnt <= '0;
    else if (tick)       cnt <= cnt + CW'(1);
  end

  AST_CORE_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(N1)); // R8

  AST_LONG_ENTRY_NEEDS_LONG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(N1) && $past(cnt) != CW'(N1)) |-> ($past(mode) == mmod_pkg::CORE_LONG)); // R8

endmodule

// File: rtl/mmod_stage_chain.sv
module mmod_stage_chain #(
  parameter int NST = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  output logic [NST-1:0] q,
  output logic           all_ones
);
  logic [NST-1:0] carry;

  assign carry[0] = adv;

  for (genvar i = 1; i < NST; i++) begin : g_carry
    assign carry[i] = carry[i-1] & q[i-1];
  end

  for (genvar i = 0; i < NST; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (carry[i]) q[i] <= ~q[i];
    end
  end

  assign all_ones = &q;

  AST_MSB_FLIPS_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q[NST-1]) |-> ($past(adv) && (q[NST-2:0] == '0))); // R2

endmodule

// File: rtl/mmod_mode_ctl.sv
module mmod_mode_ctl (
  input  logic                 all_ones,
  input  logic                 swallow_req,
  input  logic                 band_hi,
  output mmod_pkg::core_mode_e mode
);
  logic mc;

  // NAND of the stage decode and the modulus request
  assign mc = ~(all_ones & swallow_req);

  // low band: mc high -> short; high band: polarity inverted
  always_comb begin
    if (band_hi) mode = mc ? mmod_pkg::CORE_LONG  : mmod_pkg::CORE_SHORT;
    else         mode = mc ? mmod_pkg::CORE_SHORT : mmod_pkg::CORE_LONG;
  end

endmodule

// File: rtl/mmod_prescaler.sv
module mmod_prescaler #(
  parameter int N1     = 2,
  parameter int NSTAGE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_tick,
  input  logic band_hi,
  input  logic swallow_req,
  output logic div_out
);
  localparam int STG = 1 << NSTAGE;
  localparam int TW  = $clog2(STG * (N1 + 1) + 1) + 1;

  mmod_pkg::core_mode_e mode;
  logic                 core_end;
  logic [NSTAGE-1:0]    stage_q;
  logic                 stage_full;

  mmod_core23 #(.N1(N1)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (in_tick),
    .mode       (mode),
    .period_end (core_end)
  );

  mmod_stage_chain #(.NST(NSTAGE)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (core_end),
    .q        (stage_q),
    .all_ones (stage_full)
  );

  mmod_mode_ctl u_modectl (
    .all_ones    (stage_full),
    .swallow_req (swallow_req),
    .band_hi     (band_hi),
    .mode        (mode)
  );

  assign div_out = stage_q[NSTAGE-1];

  // checker state: ticks per stage-chain wrap, invalidated by a config change
  logic [TW-1:0] chk_ticks;
  logic          chk_dirty;
  logic          cfg_band_q, cfg_swal_q;
  logic          wrap_now;
  logic [TW-1:0] chk_expect;

  assign wrap_now = core_end & stage_full;

  always_comb begin
    if (band_hi) chk_expect = TW'(STG * (N1 + 1)) - TW'(swallow_req);
    else         chk_expect = TW'(STG * N1) + TW'(swallow_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_ticks  <= '0;
      chk_dirty  <= 1'b0;
      cfg_band_q <= 1'b0;
      cfg_swal_q <= 1'b0;
    end else begin
      cfg_band_q <= band_hi;
      cfg_swal_q <= swallow_req;
      if (wrap_now) begin
        chk_ticks <= '0;
        chk_dirty <= 1'b0;
      end else begin
        if (in_tick) chk_ticks <= chk_ticks + TW'(1);
        if (band_hi != cfg_band_q || swallow_req != cfg_swal_q) chk_dirty <= 1'b1;
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $rose(rst_n) |-> (div_out == 1'b0)); // R1

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !in_tick |=> ($stable(div_out) && $stable(stage_q))); // R6

  AST_RATIO_MATCHES_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_now && !chk_dirty && band_hi == cfg_band_q && swallow_req == cfg_swal_q)
      |-> (chk_ticks + TW'(1) == chk_expect)); // R7

endmodule

// File: tb/sim_mmod_prescaler.sv
`timescale 1ns/1ps
module sim_mmod_prescaler;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_tick = 1'b0;
  logic band_hi = 1'b0;
  logic swallow_req = 1'b0;
  logic div_out;

  int compared = 0;
  int mismatched = 0;

  int tick_cnt = 0;
  int rise_t = 0;
  int prev_rise = 0;
  int fall_t = 0;
  bit prev_out = 1'b0;
  bit rose_now = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  mmod_prescaler u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_tick     (in_tick),
    .band_hi     (band_hi),
    .swallow_req (swallow_req),
    .div_out     (div_out)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic tk);
    @(negedge clk);
    if (in_tick) tick_cnt++;
    rose_now = 1'b0;
    if (div_out && !prev_out) begin
      prev_rise = rise_t;
      rise_t = tick_cnt;
      rose_now = 1'b1;
    end
    if (!div_out && prev_out) fall_t = tick_cnt;
    prev_out = div_out;
    in_tick = tk;
  endtask

  function automatic logic next_tick(input bit gappy);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return gappy ? (lfsr[0] | lfsr[3]) : 1'b1;
  endfunction

  task automatic measure(input bit band, input bit md, input bit gappy, input int nper);
    int base = band ? 48 : 32;
    int per  = band ? base - int'(md) : base + int'(md);
    int lowt = base / 2;
    int seen = 0;
    int guard = 0;
    string tag;
    case ({band, md})
      2'b00:   tag = "R2";
      2'b01:   tag = "R3";
      2'b10:   tag = "R4";
      default: tag = "R5";
    endcase
    band_hi = band;
    swallow_req = md;
    while (seen < nper + 2 && guard < 4000) begin
      step(next_tick(gappy));
      guard++;
      if (rose_now) begin
        if (seen >= 2) begin
          check({tag, " period"}, rise_t - prev_rise, per);
          check({tag, " high"}, fall_t - prev_rise, per - lowt);
          check("R8 low phase", rise_t - fall_t, lowt);
          if (md) check("R7 swallow offset", rise_t - prev_rise - base, band ? -1 : 1);
        end
        seen++;
      end
    end
    if (guard >= 4000) check({tag, " no output edges"}, seen, nper + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic held;
    bit   moved;
    repeat (3) @(negedge clk);
    check("R1 output in reset", int'(div_out), 0);
    rst_n = 1'b1;
    repeat (3) step(1'b0);
    check("R1 output after release", int'(div_out), 0);

    for (int g = 0; g < 2; g++) begin
      for (int c = 0; c < 4; c++) begin
        measure(c[1], c[0], g[0], 3);
      end
    end

    // R6: a long run of idle cycles must freeze the output
    band_hi = 1'b1;
    swallow_req = 1'b1;
    repeat (37) step(1'b1);
    held = div_out;
    moved = 1'b0;
    for (int k = 0; k < 60; k++) begin
      step(1'b0);
      if (div_out !== held) moved = 1'b1;
    end
    check("R6 idle hold", int'(moved), 0);

    // R6: ticks spaced by idle cycles still give the same ratio
    measure(1'b0, 1'b1, 1'b1, 2);
    measure(1'b1, 1'b0, 1'b1, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule